// File: doc/BRIEF.md
# Cell-Mode Frame Payload Packer

This block produces the transmit byte stream of a nine-row SONET-style frame that carries fixed-length cells, four bytes per clock. Every row opens with an overhead region, and those words are copied from a separate overhead input. The rest of every row belongs to the payload region. The payload region is filled back to back with cells. Each cell consists of a one-byte link header, the cell's data bytes and a trailing BIP-8 byte. The bytes left over after the last whole cell in a frame are sent as zero pad bytes.

Cell data comes from a ready/valid word source. Each cell occupies a fixed number of 32-bit words, and the last word is only partly used. The cell length is generally not a multiple of four. A cell can also stop at the end of a row and continue after the next overhead region. For these reasons the block keeps a small byte staging buffer and packs the cell bytes onto the four output lanes at any alignment. When the source cannot keep up, the block holds its output word and its frame position until the bytes arrive.

Top module: `cp_cell_packer`

## Requirements
- R1: While reset is low, tx_valid, oh_take and cell_ready are all low. After reset is released, the first valid output word appears within four clocks and is the first overhead word of a frame.
- R2: A frame is ROWS rows of ROW_BYTES bytes each. The first OH_BYTES bytes of every row are the overhead words: tx_data equals oh_word, and oh_take is high for exactly those words. tx_frame_start is high only on the first word of a frame. Overhead words are never withheld.
- R3: cell_ready is low on every cycle in which an overhead word is emitted.
- R4: Within a word, the first byte of the stream is tx_data[31:24]. Cell bytes are packed contiguously across word and row boundaries with no gaps. After overhead, a cell resumes exactly where it stopped.
- R5: Bit 7 of a cell's link header equals bit 31 of the first input word of that cell.
- R6: Bits 6:0 of the link header hold a sequence number. It is 0 for the first cell after reset, rises by one per cell, wraps modulo 128 and continues across frames.
- R7: A cell carries CELL_BYTES-2 data bytes, taken most significant byte first from ceil((CELL_BYTES-2)/4) input words. The unused trailing bytes of the last word are dropped.
- R8: The byte that ends each cell is the bitwise XOR of that cell's header byte and all of its data bytes. The next cell's header follows it directly.
- R9: After floor(payload bytes / CELL_BYTES) cells, the remaining payload bytes of the frame are 0x00.
- R10: If the staging buffer lacks bytes needed by a payload word, tx_valid is low. The frame position, the cell state and the sequence number then hold, and no byte is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| oh_word | input | 32 | Overhead word to emit while oh_take is high |
| oh_take | output | 1 | The current output word is oh_word |
| cell_data | input | 32 | Cell data word, first byte in bits 31:24 |
| cell_valid | input | 1 | cell_data holds a word |
| cell_ready | output | 1 | The block accepts cell_data this cycle |
| tx_data | output | 32 | Output word, first byte in bits 31:24 |
| tx_valid | output | 1 | tx_data holds the next word of the frame |
| tx_frame_start | output | 1 | tx_data is the first word of a frame |

## Verification
The failures that matter most are a slipped staging-buffer pointer or a wrong fill count. Either one shifts every later payload byte by whole bytes, and the error is visible at the ports on the very next valid payload word. It then persists as wrong BIP-8 bytes for the rest of the run. A wrong cell or frame counter shows up within one cell as a header or pad byte where data was expected, or as oh_take and tx_frame_start at the wrong word. Running at full rate and again with a starved source separates errors in the stall path from errors in the packing path.

// File: rtl/cp_pkg.sv
package cp_pkg;
  localparam int LANES     = 4;
  localparam int BUF_BYTES = 8;

  typedef logic [7:0] byte_t;

  // state threaded through the byte lanes of one output word
  typedef struct packed {
    logic [15:0] pos;   // byte index inside current cell
    logic [15:0] cnt;   // cells finished in this frame
    byte_t       bip;   // running parity of current cell
    logic [6:0]  seq;   // next link sequence number
    logic [2:0]  ptr;   // staging bytes consumed so far in this word
    logic [2:0]  need;  // staging bytes referenced so far in this word
  } lane_st_t;
endpackage

// File: rtl/cp_lane_gen.sv
module cp_lane_gen
  import cp_pkg::*;
#(
  parameter int CELL_BYTES = 85,
  parameter int CELLS      = 442
) (
  input  lane_st_t                st_i,
  input  byte_t [BUF_BYTES-1:0]   buf_i,
  output byte_t                   byte_o,
  output lane_st_t                st_o
);
  localparam logic [15:0] LAST_POS = 16'(CELL_BYTES - 1);
  localparam logic [15:0] CELL_CNT = 16'(CELLS);

  always_comb begin
    st_o   = st_i;
    byte_o = '0;
    if (st_i.cnt == CELL_CNT) begin
      byte_o = '0;                                   // pad region
    end else if (st_i.pos == 16'd0) begin
      byte_o   = {buf_i[st_i.ptr][7], st_i.seq};     // header peeks next data byte
      st_o.bip = byte_o;
      st_o.seq = st_i.seq + 7'd1;
      st_o.pos = 16'd1;
      st_o.need = st_i.ptr + 3'd1;
    end else if (st_i.pos == LAST_POS) begin
      byte_o   = st_i.bip;
      st_o.pos = '0;
      st_o.cnt = st_i.cnt + 16'd1;
    end else begin
      byte_o    = buf_i[st_i.ptr];
      st_o.bip  = st_i.bip ^ byte_o;
      st_o.pos  = st_i.pos + 16'd1;
      st_o.ptr  = st_i.ptr + 3'd1;
      st_o.need = st_i.ptr + 3'd1;
    end
  end
endmodule

// File: rtl/cp_frame_pos.sv
module cp_frame_pos #(
  parameter int ROWS      = 9,
  parameter int ROW_WORDS = 1080,
  parameter int OH_WORDS  = 36
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic in_oh,
  output logic frame_first,
  output logic frame_last
);
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CW = (ROW_WORDS > 1) ? $clog2(ROW_WORDS) : 1;

  logic [RW-1:0] row_q, row_n;
  logic [CW-1:0] col_q, col_n;

  always_comb begin
    row_n = row_q;
    col_n = col_q;
    if (col_q == CW'(ROW_WORDS - 1)) begin
      col_n = '0;
      row_n = (row_q == RW'(ROWS - 1)) ? '0 : row_q + RW'(1);
    end else begin
      col_n = col_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (adv) begin
      row_q <= row_n;
      col_q <= col_n;
    end
  end

  assign in_oh       = (col_q < CW'(OH_WORDS));
  assign frame_first = (row_q == '0) && (col_q == '0);
  assign frame_last  = (row_q == RW'(ROWS - 1)) && (col_q == CW'(ROW_WORDS - 1));

  p_pos_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (col_q < CW'(ROW_WORDS)) && (row_q < RW'(ROWS)));
  p_hold_no_adv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(col_q) && $stable(row_q));
endmodule

// File: rtl/cp_byte_buf.sv
module cp_byte_buf
  import cp_pkg::*;
#(
  parameter int DATA_BYTES = 83
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   allow,
  input  logic [2:0]             consume,
  input  logic                   in_valid,
  input  logic [31:0]            in_data,
  output logic                   in_ready,
  output byte_t [BUF_BYTES-1:0]  bytes_o,
  output logic [3:0]             fill_o
);
  localparam int DW    = (DATA_BYTES + 3) / 4;
  localparam int LASTB = DATA_BYTES - 4 * (DW - 1);
  localparam int WCW   = (DW > 1) ? $clog2(DW) : 1;

  byte_t [BUF_BYTES-1:0] buf_q, buf_n, sh;
  logic  [3:0]           fill_q, fill_n, rem;
  logic  [WCW-1:0]       wcnt_q, wcnt_n;
  logic  [2:0]           pcnt;
  logic                  push;

  always_comb begin
    rem      = fill_q - {1'b0, consume};
    in_ready = allow && (rem <= 4'd4);
    push     = in_valid && in_ready;
    pcnt     = (wcnt_q == WCW'(DW - 1)) ? 3'(LASTB) : 3'd4;
    for (int i = 0; i < BUF_BYTES; i++) begin
      sh[i] = '0;
      if (4'(i) + {1'b0, consume} < 4'(BUF_BYTES))
        sh[i] = buf_q[3'(i) + consume];
    end
    buf_n = sh;
    for (int i = 0; i < BUF_BYTES; i++) begin
      for (int k = 0; k < 4; k++) begin
        if (push && (3'(k) < pcnt) && (4'(i) == rem + 4'(k)))
          buf_n[i] = in_data[31-8*k -: 8];
      end
    end
    fill_n = rem + (push ? {1'b0, pcnt} : 4'd0);
    wcnt_n = wcnt_q;
    if (push) wcnt_n = (wcnt_q == WCW'(DW - 1)) ? '0 : wcnt_q + WCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      fill_q <= '0;
      wcnt_q <= '0;
    end else begin
      buf_q  <= buf_n;
      fill_q <= fill_n;
      wcnt_q <= wcnt_n;
    end
  end

  assign bytes_o = buf_q;
  assign fill_o  = fill_q;

  p_fill_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= 4'(BUF_BYTES));
  p_take_le_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, consume} <= fill_q);
  p_src_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !allow |-> !in_ready);
endmodule

// File: rtl/cp_cell_packer.sv
module cp_cell_packer
  import cp_pkg::*;
#(
  parameter int CELL_BYTES = 85,
  parameter int OH_BYTES   = 144,
  parameter int ROW_BYTES  = 4320,
  parameter int ROWS       = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] oh_word,
  output logic        oh_take,
  input  logic [31:0] cell_data,
  input  logic        cell_valid,
  output logic        cell_ready,
  output logic [31:0] tx_data,
  output logic        tx_valid,
  output logic        tx_frame_start
);
  localparam int OH_WORDS   = OH_BYTES / 4;
  localparam int ROW_WORDS  = ROW_BYTES / 4;
  localparam int PAY_BYTES  = ROWS * (ROW_BYTES - OH_BYTES);
  localparam int CELLS      = PAY_BYTES / CELL_BYTES;
  localparam int DATA_BYTES = CELL_BYTES - 2;

  logic [1:0]  rs_q;
  logic        run, in_oh, frame_first, frame_last;
  logic        bytes_ok, pay_adv;
  logic [2:0]  consume;
  logic [3:0]  fill;
  byte_t [BUF_BYTES-1:0] stage;
  byte_t       lane_b [LANES];
  lane_st_t    st [LANES+1];

  logic [15:0] pos_q, pos_n, cnt_q, cnt_n;
  byte_t       bip_q, bip_n;
  logic [6:0]  seq_q, seq_n;

  // reset release synchroniser
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign run = rs_q[1];

  cp_frame_pos #(.ROWS(ROWS), .ROW_WORDS(ROW_WORDS), .OH_WORDS(OH_WORDS)) u_pos (
    .clk(clk), .rst_n(rst_n), .adv(tx_valid),
    .in_oh(in_oh), .frame_first(frame_first), .frame_last(frame_last));

  cp_byte_buf #(.DATA_BYTES(DATA_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .allow(run && !in_oh), .consume(consume),
    .in_valid(cell_valid), .in_data(cell_data), .in_ready(cell_ready),
    .bytes_o(stage), .fill_o(fill));

  assign st[0] = '{pos: pos_q, cnt: cnt_q, bip: bip_q, seq: seq_q, ptr: 3'd0, need: 3'd0};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    cp_lane_gen #(.CELL_BYTES(CELL_BYTES), .CELLS(CELLS)) u_lane (
      .st_i(st[l]), .buf_i(stage), .byte_o(lane_b[l]), .st_o(st[l+1]));
  end

  always_comb begin
    bytes_ok       = (fill >= {1'b0, st[LANES].need});
    pay_adv        = run && !in_oh && bytes_ok;
    tx_valid       = run && (in_oh || bytes_ok);
    oh_take        = run && in_oh;
    tx_frame_start = run && frame_first;
    consume        = pay_adv ? st[LANES].ptr : 3'd0;
    tx_data        = oh_word;
    if (!in_oh) begin
      for (int l = 0; l < LANES; l++) tx_data[31-8*l -: 8] = lane_b[l];
    end
  end

  // cell state next value
  always_comb begin
    seq_n = st[LANES].seq;
    if (frame_last) begin
      pos_n = '0;
      cnt_n = '0;
      bip_n = '0;
    end else begin
      pos_n = st[LANES].pos;
      cnt_n = st[LANES].cnt;
      bip_n = st[LANES].bip;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      cnt_q <= '0;
      bip_q <= '0;
      seq_q <= '0;
    end else if (pay_adv) begin
      pos_q <= pos_n;
      cnt_q <= cnt_n;
      bip_q <= bip_n;
      seq_q <= seq_n;
    end
  end

  p_start_is_oh_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_frame_start |-> (oh_take && tx_valid));
  p_oh_stalls_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    oh_take |-> !cell_ready);
  p_seq_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    7'(seq_q - $past(seq_q)) <= 7'd1);
  p_cell_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q < 16'(CELL_BYTES));
  p_starve_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !in_oh && !bytes_ok) |=> ($stable(pos_q) && $stable(cnt_q) && $stable(seq_q)));
  p_idle_in_reset_r1: assert property (@(posedge clk)
    !run |-> (!tx_valid && !oh_take && !cell_ready));
endmodule

// File: tb/cp_cell_packer_tb_top.sv
module cp_cell_packer_tb_top;
  localparam int CB    = 13;
  localparam int OHB   = 8;
  localparam int ROWB  = 40;
  localparam int NR    = 3;
  localparam int PROW  = ROWB - OHB;
  localparam int PAYB  = NR * PROW;
  localparam int CELLS = PAYB / CB;
  localparam int DB    = CB - 2;
  localparam int DW    = (DB + 3) / 4;
  localparam int FRB   = NR * ROWB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] oh_word = '0;
  logic [31:0] cell_data = '0;
  logic        cell_valid = 1'b0;
  logic        oh_take, cell_ready, tx_valid, tx_frame_start;
  logic [31:0] tx_data;

  cp_cell_packer #(.CELL_BYTES(CB), .OH_BYTES(OHB), .ROW_BYTES(ROWB), .ROWS(NR)) dut_i (
    .clk(clk), .rst_n(rst_n), .oh_word(oh_word), .oh_take(oh_take),
    .cell_data(cell_data), .cell_valid(cell_valid), .cell_ready(cell_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_frame_start(tx_frame_start));

  always #10 clk = ~clk;

  int vecs = 0, errs = 0, cyc = 0, fed = 0, fcnt = 0, bpos = 0, stalls = 0;
  bit acc = 0, armed = 0, starve = 0;

  function automatic logic [7:0] dat(int g, int j);
    return 8'(g * 37 + j * 11 + 5);
  endfunction

  function automatic logic [7:0] exp_pay(int f, int bi, output string tag);
    int row, col, p, c, o, g;
    logic [7:0] d0, x;
    row = bi / ROWB; col = bi % ROWB;
    p = row * PROW + col - OHB;
    c = p / CB; o = p % CB;
    if (c >= CELLS) begin tag = "R9 pad byte"; return 8'h00; end
    g  = f * CELLS + c;
    d0 = dat(g, 0);
    if (o == 0) begin tag = "R5/R6 link header"; return {d0[7], 7'(g % 128)}; end
    if (o == CB - 1) begin
      tag = "R8 parity byte";
      x = {d0[7], 7'(g % 128)};
      for (int j = 0; j < DB; j++) x ^= dat(g, j);
      return x;
    end
    tag = "R4/R7 data byte";
    return dat(g, o - 1);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic step();
    int g, w, row, col;
    string tag;
    logic [7:0] eb;
    @(negedge clk);
    if (acc) fed++;
    g = fed / DW; w = fed % DW;
    for (int k = 0; k < 4; k++)
      cell_data[31-8*k -: 8] = (4*w + k < DB) ? dat(g, 4*w + k) : 8'hEE;
    cell_valid = starve ? ((cyc % 5) < 2) : 1'b1;
    oh_word = {8'hA5, 8'(fcnt), 8'(bpos), 8'(cyc)};
    #8;
    if (rst_n && !armed && tx_valid) armed = 1;
    if (armed) begin
      row = bpos / ROWB; col = bpos % ROWB;
      if (!tx_valid) begin
        if (col < OHB) chk(0, "R2 overhead word withheld", {31'd0, tx_valid}, 32'd1);
        else stalls++;
      end else begin
        chk(tx_frame_start == (bpos == 0), "R2 frame start marker", {31'd0, tx_frame_start}, {31'd0, bpos == 0});
        chk(oh_take == (col < OHB), "R2 overhead take", {31'd0, oh_take}, {31'd0, col < OHB});
        if (col < OHB) begin
          chk(tx_data == oh_word, "R2 overhead word", tx_data, oh_word);
          chk(!cell_ready, "R3 source stalled in overhead", {31'd0, cell_ready}, 32'd0);
        end else begin
          for (int l = 0; l < 4; l++) begin
            eb = exp_pay(fcnt, bpos + l, tag);
            chk(tx_data[31-8*l -: 8] == eb, tag, {24'd0, tx_data[31-8*l -: 8]}, {24'd0, eb});
          end
        end
        bpos += 4;
        if (bpos == FRB) begin bpos = 0; fcnt++; end
      end
    end
    acc = cell_valid && cell_ready;
    cyc++;
  endtask

  task automatic t_reset();
    int n;
    rst_n = 1'b0; armed = 0;
    repeat (3) step();
    chk(!tx_valid && !cell_ready && !oh_take, "R1 outputs idle in reset",
        {29'd0, tx_valid, cell_ready, oh_take}, 32'd0);
    fed = 0; acc = 0; fcnt = 0; bpos = 0;
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    while (!armed && n < 8) begin step(); n++; end
    chk(armed && n <= 4, "R1 output starts after reset release", n, 32'd4);
  endtask

  task automatic t_stream(int frames, bit sv, string req);
    int target;
    starve = sv; stalls = 0;
    target = fcnt + frames;
    while (fcnt < target) step();
    if (sv) chk(stalls > 0, req, stalls, 32'd1);
  endtask

  initial begin
    #(20ns * 50000);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    t_reset();                                  // R1
    t_stream(20, 0, "R6 sequence wrap across frames");
    t_stream(3, 1, "R10 starved source stalls output");
    t_reset();                                  // R1 again, R6 restarts at 0
    t_stream(2, 1, "R10 starved source after reset");
    t_stream(1, 0, "R4 full rate after starvation");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule